// File: doc/BRIEF.md
# Byte Stream to SPI Word Packer

This block sits between a byte-oriented data mover and the 32-bit word path of an SPI engine. It works in both directions. On the transmit side it collects bytes into words and marks the end of a stream with a flag on the final byte. On the receive side it splits each incoming word back into bytes. A count of the bytes that remain in the stream tells it how many bytes of each word are real.

Packing always puts the earliest byte in the most significant lane that is used. A complete group of four bytes fills the word from bits 31:24 down to bits 7:0. A closing group of one to three bytes is right-justified, so its last byte lands in bits 7:0 and the unused upper lanes read zero. Unpacking follows the same rule. A bypass pin sends receive words out whole, with no change, on a separate word port.

Every data path uses a valid/ready handshake. A transfer happens on a rising clock edge when valid and ready are both high. A producer holds its data stable while valid is high and ready is low. Back-pressure on the transmit word output stops the byte input. Back-pressure on the receive byte output stops the receive word input. Back-pressure on the bypass output stops the receive word input while bypass is high.

Top module: `spi_word_packer`

## Requirements
- R1: When four bytes b0..b3 are accepted in a row without a last flag before the fourth, the packer emits one word {b0,b1,b2,b3}, with b0 in bits 31:24 and b3 in bits 7:0.
- R2: When a last flag comes on the third byte of a group, the emitted word is {8'h00,b0,b1,b2}.
- R3: When a last flag comes on the first or second byte of a group, the bytes are right-justified and the upper bits are zero: {24'h0,b0} or {16'h0,b0,b1}.
- R4: A stream of N bytes whose last byte is flagged gives exactly ceil(N/4) words. No empty word follows a group that closes on its fourth byte.
- R5: While tx_word_valid is high and tx_word_ready is low, tx_word_data stays stable and tx_byte_ready is low. No byte is lost across the stall.
- R6: A receive word with a remaining count of 4 or more is emitted as four bytes, bits 31:24 first. rx_byte_last is high only on the fourth byte, and only when the count was exactly 4.
- R7: A receive word with a remaining count k of 1 to 3 is emitted as k bytes taken from its low k lanes, the more significant lane first. rx_byte_last is high on the final byte.
- R8: A receive word with a remaining count of 0 is accepted and dropped, and no byte is emitted.
- R9: While bypass is high, each receive word appears unchanged on pass_data, no byte is emitted, and rx_word_ready follows pass_ready.
- R10: While rx_byte_valid is high and rx_byte_ready is low, rx_byte_data stays stable. With bypass low, rx_word_ready stays low until the last byte of the current word is taken.
- R11: After reset, tx_word_valid and rx_byte_valid are low, and tx_byte_ready and rx_word_ready are high when bypass and pass_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bypass | input | 1 | Route receive words whole to the pass port |
| tx_byte_valid | input | 1 | Transmit byte offered |
| tx_byte_ready | output | 1 | Packer can take a byte |
| tx_byte_data | input | 8 | Transmit byte |
| tx_byte_last | input | 1 | This byte closes the stream |
| tx_word_valid | output | 1 | Packed word available |
| tx_word_ready | input | 1 | Word consumer ready |
| tx_word_data | output | 32 | Packed word |
| rx_word_valid | input | 1 | Receive word offered |
| rx_word_ready | output | 1 | Unpacker or bypass can take a word |
| rx_word_data | input | 32 | Receive word |
| rx_word_remain | input | 16 | Bytes left in the stream, this word included |
| rx_byte_valid | output | 1 | Unpacked byte available |
| rx_byte_ready | input | 1 | Byte consumer ready |
| rx_byte_data | output | 8 | Unpacked byte |
| rx_byte_last | output | 1 | Final byte of the stream |
| pass_valid | output | 1 | Bypass word available |
| pass_ready | input | 1 | Bypass consumer ready |
| pass_data | output | 32 | Bypass word |

## Verification
A group counter that slips, or a lane register that is not cleared, shows up on the first word of the next group. The bytes appear in the wrong lanes, stale upper bits appear in a short tail, or an extra empty word is emitted. A wrong down-counter on the receive side shows within one word: a byte is missing or repeated, the byte order is wrong, the last flag lands on the wrong byte, or rx_word_ready goes high too early. Stall bugs show within the first stalled cycle, as changed output data or a byte accepted while a word is pending.

// File: rtl/spwp_pkg.sv
package spwp_pkg;
  localparam int WORD_W_DEF = 32;
  localparam int BYTE_W     = 8;
  localparam int CNT_W_DEF  = 16;
endpackage

// File: rtl/spwp_tx_pack.sv
module spwp_tx_pack #(
  parameter int WORD_W = spwp_pkg::WORD_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  localparam int LANES = WORD_W / spwp_pkg::BYTE_W;
  localparam int CW    = $clog2(LANES);

  logic [WORD_W-1:0] acc_q, word_q;
  logic [CW-1:0]     cnt_q;
  logic              word_v;

  logic              take_in, take_out, closes;
  logic [WORD_W-1:0] acc_nx;

  assign in_ready  = !word_v || out_ready;
  assign take_in   = in_valid && in_ready;
  assign take_out  = word_v && out_ready;
  assign acc_nx    = {acc_q[WORD_W-9:0], in_data};
  assign closes    = in_last || (cnt_q == CW'(LANES - 1));
  assign out_valid = word_v;
  assign out_data  = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      word_q <= '0;
      cnt_q  <= '0;
      word_v <= 1'b0;
    end else begin
      if (take_out) word_v <= 1'b0;
      if (take_in) begin
        if (closes) begin
          word_q <= acc_nx;
          word_v <= 1'b1;
          acc_q  <= '0;
          cnt_q  <= '0;
        end else begin
          acc_q <= acc_nx;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R5
  AST_TX_SHORT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    take_in && in_last && cnt_q == '0 |=> out_data[WORD_W-1:8] == '0); // R3
  AST_TX_NO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    take_in && !closes && !word_v |=> !out_valid); // R4
endmodule

// File: rtl/spwp_rx_unpack.sv
module spwp_rx_unpack #(
  parameter int WORD_W = spwp_pkg::WORD_W_DEF,
  parameter int CNT_W  = spwp_pkg::CNT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic [CNT_W-1:0]  in_rem,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              pass_valid,
  input  logic              pass_ready,
  output logic [WORD_W-1:0] pass_data
);
  localparam int LANES = WORD_W / spwp_pkg::BYTE_W;
  localparam int NW    = $clog2(LANES + 1);

  logic [WORD_W-1:0] w_q;
  logic [NW-1:0]     left_q;
  logic              end_q;

  logic              idle, big, take_w;
  logic [NW-1:0]     n_in, pos;
  logic [WORD_W-1:0] shifted;

  assign idle       = (left_q == '0);
  assign big        = (in_rem >= CNT_W'(LANES));
  assign n_in       = big ? NW'(LANES) : NW'(in_rem);
  assign in_ready   = bypass ? pass_ready : idle;
  assign pass_valid = bypass && in_valid;
  assign pass_data  = in_data;
  assign take_w     = in_valid && in_ready && !bypass;
  assign pos        = left_q - 1'b1;
  assign shifted    = w_q >> (8 * pos);
  assign out_valid  = !idle;
  assign out_data   = shifted[7:0];
  assign out_last   = end_q && (left_q == NW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q    <= '0;
      left_q <= '0;
      end_q  <= 1'b0;
    end else if (take_w) begin
      w_q    <= in_data;
      left_q <= n_in;
      end_q  <= (in_rem <= CNT_W'(LANES));
    end else if (out_valid && out_ready) begin
      left_q <= left_q - 1'b1;
    end
  end

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10
  AST_RX_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !bypass |-> !in_ready); // R10
  AST_RX_DROP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    take_w && in_rem == '0 |=> !out_valid); // R8
  AST_RX_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bypass && in_valid && in_ready && idle |=> !out_valid); // R9
endmodule

// File: rtl/spi_word_packer.sv
module spi_word_packer #(
  parameter int WORD_W = spwp_pkg::WORD_W_DEF,
  parameter int CNT_W  = spwp_pkg::CNT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass,
  input  logic              tx_byte_valid,
  output logic              tx_byte_ready,
  input  logic [7:0]        tx_byte_data,
  input  logic              tx_byte_last,
  output logic              tx_word_valid,
  input  logic              tx_word_ready,
  output logic [WORD_W-1:0] tx_word_data,
  input  logic              rx_word_valid,
  output logic              rx_word_ready,
  input  logic [WORD_W-1:0] rx_word_data,
  input  logic [CNT_W-1:0]  rx_word_remain,
  output logic              rx_byte_valid,
  input  logic              rx_byte_ready,
  output logic [7:0]        rx_byte_data,
  output logic              rx_byte_last,
  output logic              pass_valid,
  input  logic              pass_ready,
  output logic [WORD_W-1:0] pass_data
);
  spwp_tx_pack #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_byte_valid), .in_ready(tx_byte_ready),
    .in_data(tx_byte_data), .in_last(tx_byte_last),
    .out_valid(tx_word_valid), .out_ready(tx_word_ready),
    .out_data(tx_word_data)
  );

  spwp_rx_unpack #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .bypass(bypass),
    .in_valid(rx_word_valid), .in_ready(rx_word_ready),
    .in_data(rx_word_data), .in_rem(rx_word_remain),
    .out_valid(rx_byte_valid), .out_ready(rx_byte_ready),
    .out_data(rx_byte_data), .out_last(rx_byte_last),
    .pass_valid(pass_valid), .pass_ready(pass_ready),
    .pass_data(pass_data)
  );
endmodule

// File: tb/sim_spi_word_packer.sv
`timescale 1ns/1ps
module sim_spi_word_packer;
  logic clk = 0, rst_n = 0, bypass = 0;
  logic tx_byte_valid = 0, tx_byte_last = 0, tx_word_ready = 1;
  logic [7:0] tx_byte_data = 0;
  logic tx_byte_ready, tx_word_valid;
  logic [31:0] tx_word_data;
  logic rx_word_valid = 0, rx_byte_ready = 1, pass_ready = 1;
  logic [31:0] rx_word_data = 0;
  logic [15:0] rx_word_remain = 0;
  logic rx_word_ready, rx_byte_valid, rx_byte_last, pass_valid;
  logic [7:0] rx_byte_data;
  logic [31:0] pass_data;

  int checks = 0, fails = 0;
  logic [31:0] wlog [0:31]; int wn = 0;
  logic [7:0]  blog [0:63]; logic blast [0:63]; int bn = 0;
  logic [31:0] plog [0:7];  int pn = 0;

  always #2 clk = ~clk;

  spi_word_packer u0 (.*);

  always @(negedge clk) begin
    #1;
    if (rst_n && tx_word_valid && tx_word_ready && wn < 32) begin wlog[wn] = tx_word_data; wn++; end
    if (rst_n && rx_byte_valid && rx_byte_ready && bn < 64) begin
      blog[bn] = rx_byte_data; blast[bn] = rx_byte_last; bn++;
    end
    if (rst_n && pass_valid && pass_ready && pn < 8) begin plog[pn] = pass_data; pn++; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] b, input logic l);
    @(negedge clk);
    tx_byte_valid = 1; tx_byte_data = b; tx_byte_last = l;
    #1;
    while (!tx_byte_ready) begin @(negedge clk); #1; end
  endtask

  task automatic push_n(input logic [7:0] base, input int n);
    for (int i = 0; i < n; i++) push_byte(base + 8'(i), i == n - 1);
    @(negedge clk); tx_byte_valid = 0; tx_byte_last = 0;
  endtask

  task automatic send_word(input logic [31:0] w, input logic [15:0] rem);
    @(negedge clk);
    rx_word_valid = 1; rx_word_data = w; rx_word_remain = rem;
    #1;
    while (!rx_word_ready) begin @(negedge clk); #1; end
    @(negedge clk); rx_word_valid = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_reset;
    settle(1);
    chk(!tx_word_valid, "R11 tx_word_valid", 32'(tx_word_valid), 0);
    chk(!rx_byte_valid, "R11 rx_byte_valid", 32'(rx_byte_valid), 0);
    chk(tx_byte_ready,  "R11 tx_byte_ready", 32'(tx_byte_ready), 1);
    chk(rx_word_ready,  "R11 rx_word_ready", 32'(rx_word_ready), 1);
  endtask

  task automatic t_full;
    wn = 0;
    push_n(8'hA0, 8); settle(4);
    chk(wn == 2, "R4 eight bytes give two words", 32'(wn), 2);
    chk(wlog[0] == 32'hA0A1A2A3, "R1 first full word", wlog[0], 32'hA0A1A2A3);
    chk(wlog[1] == 32'hA4A5A6A7, "R1 second full word", wlog[1], 32'hA4A5A6A7);
  endtask

  task automatic t_tails;
    wn = 0;
    push_n(8'h10, 7); settle(4);
    chk(wn == 2, "R4 seven bytes give two words", 32'(wn), 2);
    chk(wlog[0] == 32'h10111213, "R1 full before tail", wlog[0], 32'h10111213);
    chk(wlog[1] == 32'h00141516, "R2 three-byte tail", wlog[1], 32'h00141516);
    wn = 0;
    push_n(8'h3C, 2); settle(4);
    chk(wn == 1 && wlog[0] == 32'h00003C3D, "R3 two-byte tail", wlog[0], 32'h00003C3D);
    wn = 0;
    push_n(8'h5A, 1); settle(4);
    chk(wn == 1 && wlog[0] == 32'h0000005A, "R3 one-byte tail", wlog[0], 32'h0000005A);
  endtask

  task automatic t_stall;
    wn = 0;
    tx_word_ready = 0;
    for (int i = 0; i < 4; i++) push_byte(8'h01 + 8'(i), 1'b0);
    @(negedge clk); tx_byte_valid = 0;
    #1;
    chk(tx_word_valid && tx_word_data == 32'h01020304, "R5 word held", tx_word_data, 32'h01020304);
    chk(!tx_byte_ready, "R5 byte input stalled", 32'(tx_byte_ready), 0);
    settle(3);
    chk(tx_word_valid && tx_word_data == 32'h01020304, "R5 word stable", tx_word_data, 32'h01020304);
    fork
      push_n(8'h05, 4);
      begin repeat (4) @(negedge clk); tx_word_ready = 1; end
    join
    settle(4);
    chk(wn == 2 && wlog[0] == 32'h01020304, "R5 first word after stall", wlog[0], 32'h01020304);
    chk(wlog[1] == 32'h05060708, "R5 no byte lost", wlog[1], 32'h05060708);
  endtask

  task automatic t_rx_full;
    bn = 0;
    send_word(32'h11223344, 16'd9); settle(6);
    chk(bn == 4, "R6 four bytes", 32'(bn), 4);
    chk({blog[0], blog[1], blog[2], blog[3]} == 32'h11223344, "R6 order",
        {blog[0], blog[1], blog[2], blog[3]}, 32'h11223344);
    chk(!(blast[0] | blast[1] | blast[2] | blast[3]), "R6 no last when more remain",
        32'({blast[0], blast[1], blast[2], blast[3]}), 0);
    bn = 0;
    send_word(32'h55667788, 16'd4); settle(6);
    chk(bn == 4 && blog[3] == 8'h88, "R6 exact four bytes", 32'(blog[3]), 32'h88);
    chk({blast[0], blast[1], blast[2], blast[3]} == 4'b0001, "R6 last on fourth byte",
        32'({blast[0], blast[1], blast[2], blast[3]}), 1);
  endtask

  task automatic t_rx_tail;
    bn = 0;
    send_word(32'hAABBCCDD, 16'd3); settle(6);
    chk(bn == 3, "R7 three bytes", 32'(bn), 3);
    chk({blog[0], blog[1], blog[2]} == 24'hBBCCDD, "R7 low lanes in order",
        32'({blog[0], blog[1], blog[2]}), 32'hBBCCDD);
    chk({blast[0], blast[1], blast[2]} == 3'b001, "R7 last on final",
        32'({blast[0], blast[1], blast[2]}), 1);
    bn = 0;
    send_word(32'hAABBCCDD, 16'd1); settle(4);
    chk(bn == 1 && blog[0] == 8'hDD && blast[0], "R7 single byte", 32'(blog[0]), 32'hDD);
  endtask

  task automatic t_rx_zero;
    bn = 0;
    send_word(32'h12345678, 16'd0); settle(4);
    chk(bn == 0, "R8 zero count emits nothing", 32'(bn), 0);
    chk(rx_word_ready && !rx_byte_valid, "R8 ready again", 32'(rx_word_ready), 1);
  endtask

  task automatic t_rx_hold;
    bn = 0;
    rx_byte_ready = 0;
    send_word(32'h9A8B7C6D, 16'd6);
    #1;
    chk(rx_byte_valid && rx_byte_data == 8'h9A, "R10 first byte held", 32'(rx_byte_data), 32'h9A);
    chk(!rx_word_ready, "R10 word input stalled", 32'(rx_word_ready), 0);
    settle(3);
    chk(rx_byte_data == 8'h9A && rx_byte_valid, "R10 byte stable", 32'(rx_byte_data), 32'h9A);
    @(negedge clk); rx_byte_ready = 1;
    settle(6);
    chk(bn == 4 && {blog[0], blog[1], blog[2], blog[3]} == 32'h9A8B7C6D, "R10 all bytes after stall",
        {blog[0], blog[1], blog[2], blog[3]}, 32'h9A8B7C6D);
  endtask

  task automatic t_bypass;
    bn = 0; pn = 0;
    @(negedge clk); bypass = 1; pass_ready = 1;
    send_word(32'hDEADBEEF, 16'd2); settle(4);
    chk(pn == 1 && plog[0] == 32'hDEADBEEF, "R9 word passed whole", plog[0], 32'hDEADBEEF);
    chk(bn == 0, "R9 no bytes in bypass", 32'(bn), 0);
    @(negedge clk); pass_ready = 0; #1;
    chk(!rx_word_ready, "R9 ready follows pass_ready", 32'(rx_word_ready), 0);
    @(negedge clk); bypass = 0; pass_ready = 1; #1;
    chk(rx_word_ready, "R9 unpacker idle after bypass", 32'(rx_word_ready), 1);
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_full;
    t_tails;
    t_stall;
    t_rx_full;
    t_rx_tail;
    t_rx_zero;
    t_rx_hold;
    t_bypass;
    report;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    report;
  end
endmodule